// File: doc/BRIEF.md
# Transceiver Power-Mode Sequencer

This block steps a low-power radio transceiver between its operating modes: powered-down, two sleep levels, the ready state, receive and transmit. The deep sleep level stops the reference oscillator; the light sleep level keeps the oscillator running so that it can wake faster. Both sleep levels disable the register interface. A wake pin brings the transceiver back from either sleep level. In light sleep, an internal timer match can also wake it when that source is enabled. Each return to the ready state, and each entry into receive or transmit, waits out a warm-up or settling delay. The length of each delay is a parameter given in clock cycles.

Sleep commands come from the register-interface decoder as a valid strobe and a two-bit code. A separate enable pin, together with a direction select, requests receive or transmit. The sequencer drives the oscillator enable, the register-interface enable, the receiver and transmitter enables, the clock-output enable, a drive enable for the digital outputs and a ready flag. While a delay runs, no request other than reset has any effect.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is Off and every enable output and ready_o are low. After release, the first clock edge selects Idle and starts a warm-up of OFF_WAKE_CYC edges. mode_o encodes Off=0, DeepSleep=1, LightSleep=2, Idle=3, Receive=4, Transmit=5.
- R2: out_oe_o, the drive enable of the digital outputs, is low in Off and high in every other mode.
- R3: A sleep command is accepted only in Idle after its warm-up ends. cmd_i=1 selects DeepSleep and cmd_i=2 selects LightSleep, and the change takes effect on the next edge. A valid command takes priority over a receive or transmit request made in the same cycle.
- R4: In DeepSleep, osc_en_o and spi_en_o are low and the mode holds until wake_i is sampled high. The block then enters Idle with a warm-up of HIB_WAKE_CYC edges.
- R5: In LightSleep, osc_en_o is high and spi_en_o is low. wake_i, or tmr_match_i while tmr_wake_en_i is high, moves the block to Idle with a warm-up of DOZE_WAKE_CYC edges. tmr_match_i has no effect while tmr_wake_en_i is low.
- R6: clko_en_o is high in Idle after warm-up and throughout Receive and Transmit. In LightSleep it is high only when clko_doze_en_i is high and clko_sel_i is at least CLKO_SLOW_SEL, meaning the selected output rate is 1 MHz or lower. It is low in every other case.
- R7: From Idle after warm-up, trx_en_i=1 enters Receive (trx_tx_i=0) or Transmit (trx_tx_i=1) on the next edge. The matching rx_en_o or tx_en_o rises at once, and ready_o rises TRX_SETTLE_CYC edges later.
- R8: In Receive or Transmit after settling, trx_en_i=0 returns the block to Idle, ready, on the next edge.
- R9: ready_o is high exactly when the mode is Idle, Receive or Transmit and no delay is running. spi_en_o is low during the Idle warm-up.
- R10: While any delay runs, wake_i, sleep commands, timer matches and changes on trx_en_i have no effect. The same holds for sleep commands issued in Receive or Transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; forces Off |
| wake_i | input | 1 | Wake request from the attention pin |
| cmd_valid_i | input | 1 | Sleep command strobe from the register decoder |
| cmd_i | input | 2 | Sleep command code (1 deep, 2 light) |
| tmr_wake_en_i | input | 1 | Allows a timer match to end LightSleep |
| tmr_match_i | input | 1 | Timer comparator match |
| trx_en_i | input | 1 | Request for receive or transmit |
| trx_tx_i | input | 1 | Direction select: 0 receive, 1 transmit |
| clko_doze_en_i | input | 1 | Allows the clock output during LightSleep |
| clko_sel_i | input | CLKO_SEL_W | Selected clock-output rate code |
| mode_o | output | 3 | Current mode code |
| ready_o | output | 1 | Mode reached and no delay running |
| osc_en_o | output | 1 | Reference oscillator enable |
| spi_en_o | output | 1 | Register interface enable |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| clko_en_o | output | 1 | Clock output enable |
| out_oe_o | output | 1 | Drive enable of the digital outputs |

## Verification
The assertions assume that every input is synchronous to clk_i and free of X. They also assume that cmd_i matters only while cmd_valid_i is high, and that reset is released away from a rising edge. The bench meets these assumptions by changing inputs and releasing reset only on falling edges, and by holding each input pattern steady across the rising edges it spans. Inputs are never left undriven. The one exception to synchronous stimulus is a deliberate asynchronous reset during Receive, which tests the forced return to Off.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_HIB  = 3'd1,
    MD_DOZE = 3'd2,
    MD_IDLE = 3'd3,
    MD_RX   = 3'd4,
    MD_TX   = 3'd5
  } mode_e;

  localparam logic [1:0] CMD_HIB  = 2'd1;
  localparam logic [1:0] CMD_DOZE = 2'd2;

endpackage

// File: rtl/xcvr_warm_cnt.sv
module xcvr_warm_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          busy_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R10: a running delay counts down one step per edge
  p_cnt_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned CW             = 8,
  parameter int unsigned OFF_WAKE_CYC   = 10,
  parameter int unsigned HIB_WAKE_CYC   = 8,
  parameter int unsigned DOZE_WAKE_CYC  = 4,
  parameter int unsigned TRX_SETTLE_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          wake_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          tmr_wake_en_i,
  input  logic          tmr_match_i,
  input  logic          trx_en_i,
  input  logic          trx_tx_i,
  output mode_e         mode_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  mode_e mode_q, mode_d;

  always_comb begin
    mode_d     = mode_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!busy_i) begin
      unique case (mode_q)
        MD_OFF: begin
          mode_d     = MD_IDLE;
          load_o     = 1'b1;
          load_val_o = CW'(OFF_WAKE_CYC);
        end
        MD_IDLE: begin
          if (cmd_valid_i && cmd_i == CMD_HIB) begin
            mode_d = MD_HIB;
          end else if (cmd_valid_i && cmd_i == CMD_DOZE) begin
            mode_d = MD_DOZE;
          end else if (trx_en_i) begin
            mode_d     = trx_tx_i ? MD_TX : MD_RX;
            load_o     = 1'b1;
            load_val_o = CW'(TRX_SETTLE_CYC);
          end
        end
        MD_HIB: begin
          if (wake_i) begin
            mode_d     = MD_IDLE;
            load_o     = 1'b1;
            load_val_o = CW'(HIB_WAKE_CYC);
          end
        end
        MD_DOZE: begin
          if (wake_i || (tmr_wake_en_i && tmr_match_i)) begin
            mode_d     = MD_IDLE;
            load_o     = 1'b1;
            load_val_o = CW'(DOZE_WAKE_CYC);
          end
        end
        MD_RX, MD_TX: begin
          if (!trx_en_i) mode_d = MD_IDLE;
        end
        default: mode_d = MD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MD_OFF;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R3: sleep is only ever entered from a settled Idle
  p_sleep_from_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_HIB || mode_q == MD_DOZE) && $past(mode_q) != mode_q)
      |-> ($past(mode_q) == MD_IDLE && !$past(busy_i)));

  // R4: deep sleep holds without a wake
  p_hib_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_HIB && !wake_i) |=> (mode_q == MD_HIB));

  // R5: light sleep holds without a wake source
  p_doze_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_DOZE && !wake_i && !(tmr_wake_en_i && tmr_match_i))
      |=> (mode_q == MD_DOZE));

  // R8: dropping the request leaves receive or transmit
  p_trx_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_RX || mode_q == MD_TX) && !busy_i && !trx_en_i)
      |=> (mode_q == MD_IDLE));

  // R10: no mode change while a delay runs
  p_warm_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/xcvr_mode_outs.sv
module xcvr_mode_outs
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned CLKO_SEL_W    = 3,
  parameter int unsigned CLKO_SLOW_SEL = 5
) (
  input  mode_e                 mode_i,
  input  logic                  busy_i,
  input  logic                  clko_doze_en_i,
  input  logic [CLKO_SEL_W-1:0] clko_sel_i,
  output logic                  osc_en_o,
  output logic                  spi_en_o,
  output logic                  rx_en_o,
  output logic                  tx_en_o,
  output logic                  clko_en_o,
  output logic                  ready_o,
  output logic                  out_oe_o
);

  logic awake, idle_warm, doze_clko_ok;

  assign awake        = (mode_i == MD_IDLE) || (mode_i == MD_RX) || (mode_i == MD_TX);
  assign idle_warm    = (mode_i == MD_IDLE) && busy_i;
  assign doze_clko_ok = clko_doze_en_i && (clko_sel_i >= CLKO_SEL_W'(CLKO_SLOW_SEL));

  assign out_oe_o  = (mode_i != MD_OFF);
  assign osc_en_o  = (mode_i != MD_OFF) && (mode_i != MD_HIB);
  assign spi_en_o  = awake && !idle_warm;
  assign rx_en_o   = (mode_i == MD_RX);
  assign tx_en_o   = (mode_i == MD_TX);
  assign ready_o   = awake && !busy_i;
  assign clko_en_o = (awake && !idle_warm) || ((mode_i == MD_DOZE) && doze_clko_ok);

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int unsigned OFF_WAKE_CYC   = 160000,
  parameter int unsigned HIB_WAKE_CYC   = 112000,
  parameter int unsigned DOZE_WAKE_CYC  = 4816,
  parameter int unsigned TRX_SETTLE_CYC = 2304,
  parameter int unsigned CLKO_SEL_W     = 3,
  parameter int unsigned CLKO_SLOW_SEL  = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wake_i,
  input  logic                  cmd_valid_i,
  input  logic [1:0]            cmd_i,
  input  logic                  tmr_wake_en_i,
  input  logic                  tmr_match_i,
  input  logic                  trx_en_i,
  input  logic                  trx_tx_i,
  input  logic                  clko_doze_en_i,
  input  logic [CLKO_SEL_W-1:0] clko_sel_i,
  output logic [2:0]            mode_o,
  output logic                  ready_o,
  output logic                  osc_en_o,
  output logic                  spi_en_o,
  output logic                  rx_en_o,
  output logic                  tx_en_o,
  output logic                  clko_en_o,
  output logic                  out_oe_o
);

  localparam int unsigned MAX_A   = (OFF_WAKE_CYC > HIB_WAKE_CYC) ? OFF_WAKE_CYC : HIB_WAKE_CYC;
  localparam int unsigned MAX_B   = (DOZE_WAKE_CYC > TRX_SETTLE_CYC) ? DOZE_WAKE_CYC : TRX_SETTLE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

  mode_e         mode;
  logic          busy, load;
  logic [CW-1:0] load_val;

  xcvr_mode_fsm #(
    .CW(CW), .OFF_WAKE_CYC(OFF_WAKE_CYC), .HIB_WAKE_CYC(HIB_WAKE_CYC),
    .DOZE_WAKE_CYC(DOZE_WAKE_CYC), .TRX_SETTLE_CYC(TRX_SETTLE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .busy_i(busy), .wake_i, .cmd_valid_i, .cmd_i,
    .tmr_wake_en_i, .tmr_match_i, .trx_en_i, .trx_tx_i,
    .mode_o(mode), .load_o(load), .load_val_o(load_val)
  );

  xcvr_warm_cnt #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .busy_o(busy)
  );

  xcvr_mode_outs #(.CLKO_SEL_W(CLKO_SEL_W), .CLKO_SLOW_SEL(CLKO_SLOW_SEL)) u_outs (
    .mode_i(mode), .busy_i(busy), .clko_doze_en_i, .clko_sel_i,
    .osc_en_o, .spi_en_o, .rx_en_o, .tx_en_o, .clko_en_o, .ready_o, .out_oe_o
  );

  assign mode_o = mode;

  // R2: with outputs undriven nothing else may be enabled
  p_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_oe_o |-> !(ready_o || osc_en_o || spi_en_o || rx_en_o || tx_en_o || clko_en_o));

  // R7: receive or transmit only starts from a settled Idle
  p_trx_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_en_o) || $rose(tx_en_o)) |-> ($past(ready_o) && $past(mode_o) == 3'd3));

  // R7: readiness in receive follows a settling period with the receiver on
  p_rx_settled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && rx_en_o) |-> $past(rx_en_o));

  // R9: the register interface never runs without the oscillator
  p_spi_osc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_o |-> osc_en_o);

endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic       wake, cv;
    logic [1:0] cmd;
    logic       ten, tm, trx, sel;
    logic [3:0] n;
    logic [2:0] md;
    logic       rdy, osc, spi, rx, tx;
    logic [3:0] rq;
  } vec_t;

  // wake cv cmd | ten tm trx sel | cycles | mode | rdy osc spi rx tx | req
  localparam vec_t VEC [NV] = '{
    24'b0101_0000_0001_001_00000_0011, // R3 deep sleep command
    24'b0000_0000_0011_001_00000_0100, // R4 holds
    24'b0110_0010_0010_001_00000_0100, // R4 command and trx ignored
    24'b1000_0000_0001_011_01000_0100, // R4 wake, warm-up
    24'b0110_0010_0100_011_01000_1010, // R10 ignored while warming
    24'b0000_0000_0001_011_11100_1001, // R9 ready
    24'b0110_0000_0001_010_01000_0101, // R5 light sleep
    24'b0000_0100_0010_010_01000_0101, // R5 match with timer wake disabled
    24'b0000_1100_0001_011_01000_0101, // R5 timer wake
    24'b0000_0000_0011_011_01000_1010, // R10 still warming
    24'b0000_0000_0001_011_11100_1001, // R9 ready
    24'b0000_0010_0001_100_01110_0111, // R7 receive entry
    24'b0000_0010_0010_100_01110_0111, // R7 settling
    24'b0000_0010_0001_100_11110_0111, // R7 settled
    24'b0000_0000_0001_011_11100_1000, // R8 back to Idle
    24'b0000_0011_0100_101_11101_0111, // R7 transmit entry and settle
    24'b0101_0011_0010_101_11101_1010, // R10 command ignored in transmit
    24'b0000_0000_0001_011_11100_1000, // R8 back to Idle
    24'b0101_0010_0001_001_00000_0011, // R3 command beats trx request
    24'b1000_0000_0110_011_11100_0100, // R4 wake, full warm-up
    24'b0110_0000_0001_010_01000_0011, // R3 light sleep command
    24'b1000_0000_0101_011_11100_0101  // R5 pin wake from light sleep
  };

  logic       clk = 1'b0;
  logic       rst_ni, wake_i, cmd_valid_i, tmr_wake_en_i, tmr_match_i;
  logic       trx_en_i, trx_tx_i, clko_doze_en_i;
  logic [1:0] cmd_i;
  logic [2:0] clko_sel_i, mode_o;
  logic       ready_o, osc_en_o, spi_en_o, rx_en_o, tx_en_o, clko_en_o, out_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_mode_ctrl #(
    .OFF_WAKE_CYC(6), .HIB_WAKE_CYC(5), .DOZE_WAKE_CYC(4), .TRX_SETTLE_CYC(3),
    .CLKO_SEL_W(3), .CLKO_SLOW_SEL(5)
  ) dut_i (
    .clk_i(clk), .rst_ni, .wake_i, .cmd_valid_i, .cmd_i, .tmr_wake_en_i, .tmr_match_i,
    .trx_en_i, .trx_tx_i, .clko_doze_en_i, .clko_sel_i, .mode_o, .ready_o, .osc_en_o,
    .spi_en_o, .rx_en_o, .tx_en_o, .clko_en_o, .out_oe_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wake_i = 0; cmd_valid_i = 0; cmd_i = 0; tmr_wake_en_i = 0; tmr_match_i = 0;
    trx_en_i = 0; trx_tx_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; idle_inputs(); clko_doze_en_i = 0; clko_sel_i = 0;
    cycles(3);
    // R1 / R2 reset state
    chk("R1", "mode in reset", mode_o, 0);
    chk("R1", "enables in reset", {ready_o, osc_en_o, spi_en_o, rx_en_o, tx_en_o, clko_en_o}, 0);
    chk("R2", "oe in reset", out_oe_o, 0);
    rst_ni = 1;
    cycles(6);
    chk("R1", "mode after release", mode_o, 3);
    chk("R1", "ready during off warm-up", ready_o, 0);
    chk("R9", "spi during warm-up", spi_en_o, 0);
    chk("R6", "clko during idle warm-up", clko_en_o, 0);
    cycles(1);
    chk("R1", "ready after off warm-up", ready_o, 1);
    chk("R2", "oe out of Off", out_oe_o, 1);
    chk("R6", "clko in idle", clko_en_o, 1);

    for (int i = 0; i < NV; i++) begin
      wake_i = VEC[i].wake; cmd_valid_i = VEC[i].cv; cmd_i = VEC[i].cmd;
      tmr_wake_en_i = VEC[i].ten; tmr_match_i = VEC[i].tm;
      trx_en_i = VEC[i].trx; trx_tx_i = VEC[i].sel;
      cycles(int'(VEC[i].n));
      chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d mode", i), mode_o, VEC[i].md);
      chk($sformatf("R%0d", VEC[i].rq), $sformatf("vec %0d outs", i),
          {ready_o, osc_en_o, spi_en_o, rx_en_o, tx_en_o},
          {VEC[i].rdy, VEC[i].osc, VEC[i].spi, VEC[i].rx, VEC[i].tx});
    end

    // R6 clock output rules in light sleep
    idle_inputs(); cmd_valid_i = 1; cmd_i = 2;
    cycles(1);
    idle_inputs();
    chk("R5", "light sleep entered", mode_o, 2);
    clko_doze_en_i = 0; clko_sel_i = 7; #1;
    chk("R6", "clko doze bit clear", clko_en_o, 0);
    clko_doze_en_i = 1; clko_sel_i = 4; #1;
    chk("R6", "clko rate too high", clko_en_o, 0);
    clko_sel_i = 5; #1;
    chk("R6", "clko rate at limit", clko_en_o, 1);
    clko_sel_i = 7; #1;
    chk("R6", "clko slowest rate", clko_en_o, 1);
    clko_doze_en_i = 0;
    wake_i = 1;
    cycles(5);
    wake_i = 0;
    chk("R5", "ready after light wake", ready_o, 1);

    // R7 receive settling clock and asynchronous reset
    trx_en_i = 1; trx_tx_i = 0;
    cycles(1);
    chk("R6", "clko during receive settling", clko_en_o, 1);
    chk("R7", "receiver on at entry", rx_en_o, 1);
    #1 rst_ni = 0; #1;
    chk("R1", "async reset forces Off", mode_o, 0);
    chk("R2", "oe low after async reset", out_oe_o, 0);
    chk("R1", "receiver off after reset", rx_en_o, 0);
    idle_inputs();
    @(negedge clk); rst_ni = 1;
    cycles(7);
    chk("R1", "ready after second release", ready_o, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule